// File: doc/BRIEF.md
# Tree-Bit LRU Replacement Selector

This block holds the replacement history for a 4-way set-associative cache with 64 sets. Each set keeps a 6-bit word. Each bit records the relative age of one pair of ways. When the cache touches a way, the word for that set moves that way to most-recently-used. On a miss, the block reads the word for the queried set and names the way to evict.

The enclosing cache controller reports every access that should refresh the history through a touch strobe. These are read hits, write hits, and the way picked for a refill. The controller presents the set it is resolving on the query port and receives the victim way and the raw history word in the same cycle. A mode input confines replacement to ways 2 and 3, so that ways 0 and 1 stay out of the replacement path. A clear strobe wipes all history.

Top module: `tree_lru_sel`

## Requirements
- R1: After reset, and in the cycle after `clear_i` is high, the history word of every set reads 0.
- R2: A touch of way 3 (`touch_way_i` = 3) sets bits 0, 1 and 3 of the touched set's word and keeps bits 2, 4 and 5.
- R3: A touch of way 2 sets bits 2 and 4, clears bit 0, and keeps bits 1, 3 and 5.
- R4: A touch of way 1 sets bit 5, clears bits 1 and 2, and keeps bits 0, 3 and 4.
- R5: A touch of way 0 clears bits 3, 4 and 5 and keeps bits 0, 1 and 2.
- R6: With `two_way_i` low, the victim is chosen by the first of these tests that holds. Way 0 is chosen when bits 3, 4 and 5 are all 1. Way 1 is chosen when bits 1 and 2 are 1 and bit 5 is 0. Way 2 is chosen when bit 0 is 1 and bits 2 and 4 are 0. Way 3 is chosen when bits 0, 1 and 3 are all 0.
- R7: With `two_way_i` high, the victim is way 2 when bit 0 of the word is 1 and way 3 when it is 0.
- R8: `hist_o` and `victim_way_o` follow the set on `query_set_i` in the same cycle. A touch becomes visible in the cycle after its strobe. A query to the set being touched in the same cycle returns the value from before the update.
- R9: A touch changes only the word of the set it names. All other sets keep their words.
- R10: When `clear_i` and `touch_vld_i` are high in the same cycle, the clear wins and the touched set also reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Zero all history words on this edge |
| touch_vld_i | input | 1 | Touch strobe |
| touch_set_i | input | 6 | Set being touched |
| touch_way_i | input | 2 | Way being touched |
| query_set_i | input | 6 | Set being queried |
| two_way_i | input | 1 | Confine replacement to ways 2 and 3 |
| victim_way_o | output | 2 | Way to replace in the queried set |
| hist_o | output | 6 | History word of the queried set |

## Verification
The victim and the history word are combinational reads of the stored words. The bench checks them 1 ns after it drives the inputs in each cycle, before the next rising edge. A touch or clear is applied to the bench's model only at the rising edge that follows the strobe. A query in that same cycle is therefore compared with the old word, and the new word is expected one cycle later. The model is compared on every clock, through directed sequences for each way's masks and for every victim rule, and then through a long pseudo-random mix of sets, ways and modes.

// File: rtl/tlru_pkg.sv
// Package: shared types and per-way update masks for the tree-bit LRU selector.
// Assumes a fixed four-way organisation; bit i of a history word orders one pair of ways.
package tlru_pkg;
    localparam int HIST_W = 6;
    localparam int WAYS   = 4;
    localparam int WAY_W  = $clog2(WAYS);

    typedef logic [HIST_W-1:0] hist_t;
    typedef logic [WAY_W-1:0]  way_t;

    // Bits forced to 1 when a way becomes most recently used.
    localparam hist_t SET_MASK [WAYS] = '{6'b000000, 6'b100000, 6'b010100, 6'b001011};
    // Bits forced to 0 when a way becomes most recently used.
    localparam hist_t CLR_MASK [WAYS] = '{6'b111000, 6'b000110, 6'b000001, 6'b000000};
endpackage

// File: rtl/tlru_touch_upd.sv
// Module: computes the history word that results from touching one way.
// Assumes the touched way is always a legal index; purely combinational.
module tlru_touch_upd
    import tlru_pkg::*;
(
    input  hist_t cur_i,
    input  way_t  way_i,
    output hist_t nxt_i
);
    hist_t set_m;
    hist_t clr_m;

    // Select the per-way masks for the touched way.
    always_comb begin
        set_m = '0;
        clr_m = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_i == way_t'(w)) begin
                set_m = SET_MASK[w];
                clr_m = CLR_MASK[w];
            end
        end
    end

    assign nxt_i = (cur_i & ~clr_m) | set_m;
endmodule

// File: rtl/tlru_victim_pick.sv
// Module: decides which way to evict from one history word.
// Assumes a four-way word; in two-way mode only ways 2 and 3 are candidates.
// An unmatched word falls back to way 0 so the output is always defined.
module tlru_victim_pick
    import tlru_pkg::*;
(
    input  hist_t h_i,
    input  logic  two_way_i,
    output way_t  victim_o
);
    // Ordered victim decision.
    always_comb begin
        if (two_way_i)
            victim_o = h_i[0] ? way_t'(2) : way_t'(3);
        else if (h_i[5] && h_i[4] && h_i[3])
            victim_o = way_t'(0);
        else if (!h_i[5] && h_i[2] && h_i[1])
            victim_o = way_t'(1);
        else if (!h_i[4] && !h_i[2] && h_i[0])
            victim_o = way_t'(2);
        else if (!h_i[3] && !h_i[1] && !h_i[0])
            victim_o = way_t'(3);
        else
            victim_o = way_t'(0);
    end
endmodule

// File: rtl/tlru_hist_store.sv
// Module: one history register per set, with one write port and two asynchronous read ports.
// Assumes clear and reset both zero every word; clear takes priority over a write.
module tlru_hist_store
    import tlru_pkg::*;
#(
    parameter int SETS  = 64,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             wr_en_i,
    input  logic [SET_W-1:0] wr_set_i,
    input  hist_t            wr_data_i,
    input  logic [SET_W-1:0] rd_a_set_i,
    output hist_t            rd_a_o,
    input  logic [SET_W-1:0] rd_b_set_i,
    output hist_t            rd_b_o
);
    hist_t words [SETS];

    for (genvar g = 0; g < SETS; g++) begin : g_set
        // Hold, clear or load the history word of set g.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i)
                words[g] <= '0;
            else if (wr_en_i && wr_set_i == SET_W'(g))
                words[g] <= wr_data_i;
        end
    end

    assign rd_a_o = words[rd_a_set_i];
    assign rd_b_o = words[rd_b_set_i];
endmodule

// File: rtl/tree_lru_sel.sv
// Module: top of the tree-bit LRU replacement selector.
// Touches update the named set's word at the next edge.
// Queries read the current word combinationally and return it with its victim way.
module tree_lru_sel
    import tlru_pkg::*;
#(
    parameter int SETS  = 64,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             touch_vld_i,
    input  logic [SET_W-1:0] touch_set_i,
    input  logic [1:0]       touch_way_i,
    input  logic [SET_W-1:0] query_set_i,
    input  logic             two_way_i,
    output logic [1:0]       victim_way_o,
    output logic [5:0]       hist_o
);
    hist_t touch_cur;
    hist_t touch_nxt;
    hist_t query_cur;
    way_t  victim;

    tlru_hist_store #(.SETS(SETS)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .wr_en_i    (touch_vld_i),
        .wr_set_i   (touch_set_i),
        .wr_data_i  (touch_nxt),
        .rd_a_set_i (touch_set_i),
        .rd_a_o     (touch_cur),
        .rd_b_set_i (query_set_i),
        .rd_b_o     (query_cur)
    );

    tlru_touch_upd upd_i (
        .cur_i (touch_cur),
        .way_i (way_t'(touch_way_i)),
        .nxt_i (touch_nxt)
    );

    tlru_victim_pick pick_i (
        .h_i       (query_cur),
        .two_way_i (two_way_i),
        .victim_o  (victim)
    );

    assign victim_way_o = 2'(victim);
    assign hist_o       = 6'(query_cur);
endmodule

// File: rtl/tree_lru_sel_chk.sv
// Module: property checker for tree_lru_sel, attached through bind.
// Assumes it sees only the top-level ports.
module tree_lru_sel_chk #(
    parameter int SET_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_i,
    input logic             touch_vld_i,
    input logic [SET_W-1:0] touch_set_i,
    input logic [1:0]       touch_way_i,
    input logic [SET_W-1:0] query_set_i,
    input logic             two_way_i,
    input logic [1:0]       victim_way_o,
    input logic [5:0]       hist_o
);
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> hist_o == 6'd0); // R1

    AST_WAY3_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_vld_i && touch_way_i == 2'd3 && !clear_i) ##1 (query_set_i == $past(touch_set_i))
        |-> (hist_o[3] && hist_o[1] && hist_o[0])); // R2

    AST_WAY0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_vld_i && touch_way_i == 2'd0 && !clear_i) ##1 (query_set_i == $past(touch_set_i))
        |-> (hist_o[5:3] == 3'b000)); // R5

    AST_WAY0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!two_way_i && hist_o[5:3] == 3'b111) |-> victim_way_o == 2'd0); // R6

    AST_TWO_WAY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        two_way_i |-> victim_way_o == (hist_o[0] ? 2'd2 : 2'd3)); // R7

    AST_OTHER_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clear_i) && query_set_i == $past(query_set_i)
         && !($past(touch_vld_i) && $past(touch_set_i) == query_set_i))
        |-> $stable(hist_o)); // R9
endmodule

bind tree_lru_sel tree_lru_sel_chk #(.SET_W(SET_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear_i),
    .touch_vld_i  (touch_vld_i),
    .touch_set_i  (touch_set_i),
    .touch_way_i  (touch_way_i),
    .query_set_i  (query_set_i),
    .two_way_i    (two_way_i),
    .victim_way_o (victim_way_o),
    .hist_o       (hist_o)
);

// File: tb/tree_lru_sel_tb_top.sv
`timescale 1ns/1ps
module tree_lru_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0;
    logic       touch_vld_i = 1'b0;
    logic [5:0] touch_set_i = '0;
    logic [1:0] touch_way_i = '0;
    logic [5:0] query_set_i = '0;
    logic       two_way_i = 1'b0;
    logic [1:0] victim_way_o;
    logic [5:0] hist_o;

    int n_run  = 0;
    int n_fail = 0;
    int model [64];

    always #2.5 clk = ~clk;

    tree_lru_sel dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear_i),
        .touch_vld_i  (touch_vld_i),
        .touch_set_i  (touch_set_i),
        .touch_way_i  (touch_way_i),
        .query_set_i  (query_set_i),
        .two_way_i    (two_way_i),
        .victim_way_o (victim_way_o),
        .hist_o       (hist_o)
    );

    // Victim expected from the requirement rules.
    function automatic int exp_victim(int h, bit two);
        if (two) return h[0] ? 2 : 3;
        if (h[5] && h[4] && h[3]) return 0;
        if (!h[5] && h[2] && h[1]) return 1;
        if (!h[4] && !h[2] && h[0]) return 2;
        if (!h[3] && !h[1] && !h[0]) return 3;
        return 0;
    endfunction

    // Behavioural effect of a touch (R2..R5).
    function automatic int apply_touch(int h, int way);
        case (way)
            3: return h | 11;
            2: return (h & ~1) | 20;
            1: return (h | 32) & ~6;
            default: return h & ~56;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check 1 ns later, update the model at the rising edge.
    task automatic cyc(bit clr, bit tv, int ts, int tw, int qs, bit two, string htag);
        clear_i = clr; touch_vld_i = tv; touch_set_i = 6'(ts);
        touch_way_i = 2'(tw); query_set_i = 6'(qs); two_way_i = two;
        #1;
        check(htag, int'(hist_o), model[qs]);
        check(two ? "R7 victim" : "R6 victim", int'(victim_way_o), exp_victim(model[qs], two));
        @(posedge clk);
        if (clr) begin
            for (int i = 0; i < 64; i++) model[i] = 0;
        end else if (tv) begin
            model[ts] = apply_touch(model[ts], tw);
        end
        @(negedge clk);
    endtask

    initial begin
        #900000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int lfsr;
        for (int i = 0; i < 64; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state for edge sets; R6 victim of a zero word is way 3.
        cyc(0, 0, 0, 0, 0, 0, "R1 reset set0");
        cyc(0, 0, 0, 0, 63, 0, "R1 reset set63");
        // R8: same-cycle query sees the old word; R2 visible next cycle.
        cyc(0, 1, 5, 3, 5, 0, "R8 pre-update");
        cyc(0, 0, 0, 0, 5, 0, "R2 way3 touch");
        cyc(0, 1, 5, 2, 5, 0, "R8 pre-update");
        cyc(0, 0, 0, 0, 5, 0, "R3 way2 touch");
        cyc(0, 1, 5, 1, 5, 0, "R8 pre-update");
        cyc(0, 0, 0, 0, 5, 0, "R4 way1 touch");
        cyc(0, 1, 5, 0, 5, 0, "R8 pre-update");
        cyc(0, 0, 0, 0, 5, 0, "R5 way0 touch");
        // R9: touches to set 7 leave set 6 alone.
        cyc(0, 1, 7, 2, 6, 0, "R9 other set");
        cyc(0, 1, 7, 1, 6, 0, "R9 other set");
        cyc(0, 0, 0, 0, 7, 0, "R4 way1 after way2");
        // R7: two-way mode picks from bit 0.
        cyc(0, 1, 9, 3, 9, 1, "R7 before");
        cyc(0, 1, 9, 2, 9, 1, "R2 two-way word");
        cyc(0, 0, 0, 0, 9, 1, "R3 two-way word");
        // R10: clear with a simultaneous touch; R1 every set zero afterwards.
        cyc(1, 1, 5, 3, 5, 0, "R10 pre-clear");
        for (int s = 0; s < 64; s++) cyc(0, 0, 0, 0, s, 0, "R1 after clear");
        // R6/R8/R9: pseudo-random mix compared against the model every cycle.
        lfsr = 16'hACE1;
        for (int k = 0; k < 2000; k++) begin
            lfsr = ((lfsr >> 1) | (((lfsr ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
            cyc(((lfsr & 16'h03FF) == 0), lfsr[13], lfsr & 3, (lfsr >> 2) & 3,
                (lfsr[12] ? (lfsr & 3) : ((lfsr >> 6) & 3)), lfsr[14], "R9 random mix");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule